// File: doc/BRIEF.md
# Pipeline Exception Capture and Flush Controller

This controller sits beside a five-stage in-order pipeline and reacts to two exception kinds: an undefined instruction, recognised in the decode stage, and an arithmetic overflow, recognised in the execute stage. Each stage reports its exception together with the PC+4 value that travels with its instruction. When an exception is taken, the controller does three things in the same cycle. It selects the fixed handler entry address on the fetch PC multiplexer. It raises flush strobes that squash the faulting instruction and every younger instruction. It captures a 32-bit exception PC (the faulting address plus 4) and a 32-bit cause code.

The flush strobes have fixed meanings. The fetch-stage flush clears the instruction word entering decode. The decode-stage flush is combined by OR with the pipeline's load-use stall request into a single "zero decode controls" output. The execute-stage flush clears the execute-stage control lines, so an overflowing instruction never writes its result back. If both stages report in the same cycle, the execute-stage overflow wins because it belongs to the older instruction. The decode-stage report is simply flushed.

The controller is a two-state machine. ST_RUN is the normal state. A taken exception moves it to ST_SETTLE (transition "take"). For the one cycle spent in ST_SETTLE, the decode and execute stages hold only the bubbles the flush produced, so exception reports are ignored. The machine then returns unconditionally to ST_RUN (transition "resume").

Top module: `exc_flush_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, epc and cause read 0. With no exception reported, if_flush, id_flush, ex_flush and pc_redirect are 0.
- R2: In ST_RUN, when dec_undef is 1 and ex_ovf is 0, the exception is taken. In that same cycle if_flush=1, id_flush=1 and ex_flush=0. After the next rising edge, cause=10 and epc equals the dec_pc4 value that was presented.
- R3: In ST_RUN, when ex_ovf is 1, the exception is taken. In that same cycle if_flush, id_flush and ex_flush are all 1; ex_flush blocks the faulting instruction's write-back. After the next rising edge, cause=12 and epc equals the ex_pc4 value that was presented.
- R4: When dec_undef and ex_ovf are both 1 in ST_RUN, the overflow is recorded: cause=12 and epc=ex_pc4.
- R5: pc_redirect is 1 exactly in the cycle an exception is taken. exc_vector always equals 0x80000180.
- R6: epc and cause change only on the rising edge that ends a cycle in which an exception was taken. At every other edge they hold their value.
- R7: In the cycle right after a taken exception (ST_SETTLE), dec_undef and ex_ovf are ignored: all flushes and pc_redirect are 0, and epc and cause hold. The following cycle is back in ST_RUN.
- R8: id_ctl_zero equals id_flush OR hz_stall in every cycle.
- R9: In ST_RUN with neither exception reported, no flush and no redirect is raised; id_ctl_zero then follows hz_stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_undef | input | 1 | Decode stage holds an undefined instruction |
| dec_pc4 | input | 32 | PC+4 of the decode-stage instruction |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc4 | input | 32 | PC+4 of the execute-stage instruction |
| hz_stall | input | 1 | Load-use stall request from the hazard detector |
| pc_redirect | output | 1 | Select handler entry on the fetch PC multiplexer |
| exc_vector | output | 32 | Handler entry address |
| if_flush | output | 1 | Clear the instruction entering decode |
| id_flush | output | 1 | Flush the decode-stage instruction |
| ex_flush | output | 1 | Clear execute-stage control lines |
| id_ctl_zero | output | 1 | Zero decode-stage controls (flush or stall) |
| epc | output | 32 | Saved faulting address plus 4 |
| cause | output | 32 | Saved cause code (10 undefined, 12 overflow) |

## Verification
Several properties are checked by assertions on every cycle:
- an execute flush only ever comes with an overflow redirect;
- a redirect always flushes fetch and decode;
- a redirect is never followed by another redirect on the next cycle;
- a stall always zeroes the decode controls;
- the saved registers hold unless a load occurs;
- the older overflow always wins arbitration.

Only the bench scenarios can show the exact captured values across mixed sequences. Examples are back-to-back reports where the second must be ignored, simultaneous reports, and long random runs in which a reference model predicts epc and cause after every edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [0:0] {
        ST_RUN,
        ST_SETTLE
    } exc_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_DEC,
        SRC_EXE
    } exc_src_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CODE_UNDEF = 10,
    parameter int unsigned CODE_OVF   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  logic            dec_undef,
    input  logic [XLEN-1:0] dec_pc4,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc4,
    output logic            take,
    output exc_src_e        src,
    output logic [XLEN-1:0] sel_pc4,
    output logic [XLEN-1:0] sel_code
);
    localparam logic [XLEN-1:0] UNDEF_V = XLEN'(CODE_UNDEF);
    localparam logic [XLEN-1:0] OVF_V   = XLEN'(CODE_OVF);

    // Older instruction (execute) has priority over the younger (decode).
    always_comb begin
        src      = SRC_NONE;
        sel_pc4  = '0;
        sel_code = '0;
        if (armed && ex_ovf) begin
            src      = SRC_EXE;
            sel_pc4  = ex_pc4;
            sel_code = OVF_V;
        end else if (armed && dec_undef) begin
            src      = SRC_DEC;
            sel_pc4  = dec_pc4;
            sel_code = UNDEF_V;
        end
    end

    assign take = (src != SRC_NONE);

    a_r4_older_wins: assert property (@(posedge clk) disable iff (rst)
        (take && ex_ovf) |-> (src == SRC_EXE && sel_code == OVF_V && sel_pc4 == ex_pc4));

    a_r2_undef_code: assert property (@(posedge clk) disable iff (rst)
        (take && !ex_ovf) |-> (sel_code == UNDEF_V && sel_pc4 == dec_pc4));
endmodule

// File: rtl/exc_regs.sv
module exc_regs #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] pc4,
    input  logic [XLEN-1:0] code,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc   <= '0;
            cause <= '0;
        end else if (load) begin
            epc   <= pc4;
            cause <= code;
        end
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(epc) && $stable(cause)));

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (epc == $past(pc4) && cause == $past(code)));
endmodule

// File: rtl/exc_flush_fsm.sv
module exc_flush_fsm
    import exc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  exc_src_e src,
    input  logic     hz_stall,
    output logic     armed,
    output logic     pc_redirect,
    output logic     if_flush,
    output logic     id_flush,
    output logic     ex_flush,
    output logic     id_ctl_zero
);
    exc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        armed       = 1'b0;
        pc_redirect = 1'b0;
        if_flush    = 1'b0;
        id_flush    = 1'b0;
        ex_flush    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                armed = 1'b1;
                if (take) begin
                    pc_redirect = 1'b1;
                    if_flush    = 1'b1;
                    id_flush    = 1'b1;
                    ex_flush    = (src == SRC_EXE);
                    state_d     = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
        id_ctl_zero = id_flush | hz_stall;
    end

    a_r3_ex_flush_only_ovf: assert property (@(posedge clk) disable iff (rst)
        ex_flush |-> (pc_redirect && src == SRC_EXE));

    a_r5_redirect_flushes: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> (if_flush && id_flush));

    a_r7_settle_quiet: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |=> (!pc_redirect && !if_flush && !id_flush && !ex_flush));

    a_r8_stall_zero: assert property (@(posedge clk) disable iff (rst)
        hz_stall |-> id_ctl_zero);
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CODE_UNDEF = 10,
    parameter int unsigned CODE_OVF   = 12,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_undef,
    input  logic [XLEN-1:0] dec_pc4,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc4,
    input  logic            hz_stall,
    output logic            pc_redirect,
    output logic [XLEN-1:0] exc_vector,
    output logic            if_flush,
    output logic            id_flush,
    output logic            ex_flush,
    output logic            id_ctl_zero,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause
);
    logic            armed;
    logic            take;
    exc_src_e        src;
    logic [XLEN-1:0] sel_pc4;
    logic [XLEN-1:0] sel_code;

    assign exc_vector = VECTOR;

    exc_arbiter #(
        .XLEN(XLEN), .CODE_UNDEF(CODE_UNDEF), .CODE_OVF(CODE_OVF)
    ) u_arb (
        .clk(clk), .rst(rst), .armed(armed),
        .dec_undef(dec_undef), .dec_pc4(dec_pc4),
        .ex_ovf(ex_ovf), .ex_pc4(ex_pc4),
        .take(take), .src(src), .sel_pc4(sel_pc4), .sel_code(sel_code)
    );

    exc_flush_fsm u_fsm (
        .clk(clk), .rst(rst), .take(take), .src(src), .hz_stall(hz_stall),
        .armed(armed), .pc_redirect(pc_redirect), .if_flush(if_flush),
        .id_flush(id_flush), .ex_flush(ex_flush), .id_ctl_zero(id_ctl_zero)
    );

    exc_regs #(.XLEN(XLEN)) u_regs (
        .clk(clk), .rst(rst), .load(take),
        .pc4(sel_pc4), .code(sel_code), .epc(epc), .cause(cause)
    );

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (!dec_undef && !ex_ovf) |-> (!pc_redirect && !if_flush && !id_flush && !ex_flush));
endmodule

// File: tb/exc_flush_ctrl_tb_top.sv
module exc_flush_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        dec_undef, ex_ovf, hz_stall;
    logic [31:0] dec_pc4, ex_pc4;
    logic        pc_redirect, if_flush, id_flush, ex_flush, id_ctl_zero;
    logic [31:0] exc_vector, epc, cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic        m_settle;
    logic [31:0] m_epc, m_cause;

    always #5 clk = ~clk;

    exc_flush_ctrl dut_i (
        .clk(clk), .rst(rst), .dec_undef(dec_undef), .dec_pc4(dec_pc4),
        .ex_ovf(ex_ovf), .ex_pc4(ex_pc4), .hz_stall(hz_stall),
        .pc_redirect(pc_redirect), .exc_vector(exc_vector),
        .if_flush(if_flush), .id_flush(id_flush), .ex_flush(ex_flush),
        .id_ctl_zero(id_ctl_zero), .epc(epc), .cause(cause)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_code(input logic o);
        return o ? 32'd12 : 32'd10;
    endfunction

    // One pipeline cycle: drive at negedge, check combinational outputs, then registers after the edge.
    task automatic step(input logic u, input logic o, input logic s, input logic [31:0] dp, input logic [31:0] ep);
        logic tk;
        @(negedge clk);
        dec_undef = u; ex_ovf = o; hz_stall = s; dec_pc4 = dp; ex_pc4 = ep;
        #1;
        tk = !m_settle && (u || o);
        chk(pc_redirect == tk, "R5 redirect", 32'(pc_redirect), 32'(tk));
        chk(exc_vector == 32'h8000_0180, "R5 vector", exc_vector, 32'h8000_0180);
        chk(if_flush == tk && id_flush == tk, "R2/R3/R7/R9 if_id_flush", {if_flush, id_flush}, {tk, tk});
        chk(ex_flush == (!m_settle && o), "R3 ex_flush", 32'(ex_flush), 32'(!m_settle && o));
        chk(id_ctl_zero == (tk || s), "R8 id_ctl_zero", 32'(id_ctl_zero), 32'(tk || s));
        if (tk) begin
            m_cause = exp_code(o);
            m_epc   = o ? ep : dp;
        end
        m_settle = tk;
        @(posedge clk); #1;
        chk(epc == m_epc, "R2/R3/R4/R6/R7 epc", epc, m_epc);
        chk(cause == m_cause, "R2/R3/R4/R6/R7 cause", cause, m_cause);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; dec_undef = 0; ex_ovf = 0; hz_stall = 0; dec_pc4 = 0; ex_pc4 = 0;
        m_settle = 0; m_epc = 0; m_cause = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(epc == 0 && cause == 0, "R1 reset regs", epc | cause, 0);
        chk(!pc_redirect && !if_flush && !id_flush && !ex_flush, "R1 reset flush",
            {pc_redirect, if_flush, id_flush, ex_flush}, 0);
        rst = 1'b0;
        // Directed: idle, stall only (R9, R8)
        step(0, 0, 0, 32'h100, 32'h200);
        step(0, 0, 1, 32'h104, 32'h204);
        // R2 undefined alone
        step(1, 0, 0, 32'h0000_1004, 32'h0000_1000);
        step(0, 0, 0, 32'h0, 32'h0);
        // R3 overflow alone
        step(0, 1, 0, 32'h0000_2008, 32'h0000_2004);
        step(0, 0, 0, 32'h0, 32'h0);
        // R4 both at once
        step(1, 1, 1, 32'h0000_300c, 32'h0000_3008);
        // R7 reports right after a take are ignored
        step(1, 1, 0, 32'hdead_0004, 32'hbeef_0004);
        step(0, 1, 0, 32'h0000_4010, 32'h0000_400c);
        step(1, 0, 0, 32'h0000_5014, 32'h0000_5010);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
                 $urandom & 32'hffff_fffc, $urandom & 32'hffff_fffc);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule